// File: doc/BRIEF.md
# Tag Core Power-State Sequencer

This block sequences the working states of the digital core of a passive RFID tag. It holds the core in one of five states (startup, standby, receive, control and transmit). In each state it raises a fixed set of enables, one per submodule: power management, symbol detector, command decoder, control unit, memory access, volatile shadow store and transmitter. Submodules that the current state does not need stay gated off. This spreads the power draw of the core over time.

At reset the core is in startup. In this state the contents of the non-volatile memory are copied into a cheaper volatile shadow. The copy logic pulses a word strobe for every word it moves, and then raises a done flag. The sequencer leaves startup only when done is seen and the number of counted words has reached a programmable length. After startup, every read is served from the shadow. The core then loops: standby, receive, control, then either transmit or straight back to standby when the command needs no reply.

All enables are registered. Each enable changes cleanly on the clock edge after the state register changes.

Top module: `tag_power_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` reads 0 (startup) and the enables show the startup set.
- R2: Startup counts `copy_word_i` pulses, saturating at the counter maximum. The counted value is the one held before this cycle's pulse. The state moves to standby (1) only in a cycle where `copy_done_i` is high and that count is at least `copy_len_i`. No path leads back to startup other than reset.
- R3: In standby, `sof_i` moves the state to receive (2).
- R4: In receive, `frame_end_i` moves the state to control (3).
- R5: In control, `no_resp_i` moves the state to standby (1), and it wins over `reply_rdy_i`. Otherwise `reply_rdy_i` moves the state to transmit (4).
- R6: In transmit, `resp_sent_i` moves the state to standby (1).
- R7: Enable sets per state, where power management is on in every state:
  - startup: control, memory and shadow.
  - standby: symbol detector.
  - receive: symbol detector, command decoder and memory.
  - control: control, memory and shadow.
  - transmit: memory and transmitter.
- R8: The enables follow the state with one cycle of latency. They show the set of the state held in the previous cycle.
- R9: `en_pm_o` is high in every state.
- R10: Any handshake input that is not listed for the current state leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, forces startup |
| copy_len_i | input | CNT_W | Number of words the startup copy must move |
| copy_word_i | input | 1 | One word copied into the shadow |
| copy_done_i | input | 1 | Copy logic reports completion |
| sof_i | input | 1 | Start of a reader frame detected |
| frame_end_i | input | 1 | Whole reader frame received |
| reply_rdy_i | input | 1 | Control unit has a reply ready to send |
| no_resp_i | input | 1 | Command needs no reply |
| resp_sent_i | input | 1 | Transmitter finished the reply |
| state_o | output | 3 | Current working state (0 to 4) |
| en_pm_o | output | 1 | Power-management enable |
| en_symdet_o | output | 1 | Symbol detector enable |
| en_cmddec_o | output | 1 | Command decoder enable |
| en_ctrl_o | output | 1 | Control unit enable |
| en_mem_o | output | 1 | Memory access enable |
| en_shadow_o | output | 1 | Volatile shadow enable |
| en_tx_o | output | 1 | Transmitter enable |

## Verification
A wrong state register shows on `state_o` right after the edge that loads it. One cycle later it also shows as an enable set from another row of the map, so each bad transition is visible within two cycles. A miscounting copy counter shows as an early or late exit from startup, which the sweep over copy lengths and word counts pins to one exact cycle. Each stray handshake in every state is checked for having no effect on the next cycle's state.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [2:0] {
    ST_STARTUP  = 3'd0,
    ST_STANDBY  = 3'd1,
    ST_RECEIVE  = 3'd2,
    ST_CONTROL  = 3'd3,
    ST_TRANSMIT = 3'd4
  } tps_state_e;

  typedef struct packed {
    logic pm;
    logic symdet;
    logic cmddec;
    logic ctrl;
    logic mem;
    logic shadow;
    logic tx;
  } tps_en_t;

  // Fixed per-state enable set
  function automatic tps_en_t en_for_state(tps_state_e s);
    tps_en_t e;
    e = '0;
    e.pm = 1'b1;
    case (s)
      ST_STARTUP:  begin e.ctrl = 1'b1; e.mem = 1'b1; e.shadow = 1'b1; end
      ST_STANDBY:  begin e.symdet = 1'b1; end
      ST_RECEIVE:  begin e.symdet = 1'b1; e.cmddec = 1'b1; e.mem = 1'b1; end
      ST_CONTROL:  begin e.ctrl = 1'b1; e.mem = 1'b1; e.shadow = 1'b1; end
      ST_TRANSMIT: begin e.mem = 1'b1; e.tx = 1'b1; end
      default:     e = '0;
    endcase
    return e;
  endfunction

  // Copy length check: count already moved vs requested
  function automatic logic words_reached(logic [31:0] cnt, logic [31:0] len);
    return cnt >= len;
  endfunction

endpackage

// File: rtl/tps_copy_counter.sv
module tps_copy_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             word_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             count_ok_o
);
  import tps_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_inc;

  assign cnt_inc = active_i && word_i && (cnt_q != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  assign count_ok_o = words_reached(32'(cnt_q), 32'(len_i));

  AST_CNT_FROZEN_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(cnt_q)); // R2
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R2

endmodule

// File: rtl/tps_state_fsm.sv
module tps_state_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                copy_done_i,
  input  logic                count_ok_i,
  input  logic                sof_i,
  input  logic                frame_end_i,
  input  logic                reply_rdy_i,
  input  logic                no_resp_i,
  input  logic                resp_sent_i,
  output tps_pkg::tps_state_e state_o,
  output logic                in_startup_o
);
  import tps_pkg::*;

  tps_state_e state_q, state_d;
  logic       leave_startup;

  assign leave_startup = copy_done_i && count_ok_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_STARTUP:  if (leave_startup) state_d = ST_STANDBY;
      ST_STANDBY:  if (sof_i)         state_d = ST_RECEIVE;
      ST_RECEIVE:  if (frame_end_i)   state_d = ST_CONTROL;
      ST_CONTROL: begin
        if (no_resp_i)        state_d = ST_STANDBY;
        else if (reply_rdy_i) state_d = ST_TRANSMIT;
      end
      ST_TRANSMIT: if (resp_sent_i)   state_d = ST_STANDBY;
      default:                        state_d = ST_STARTUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STARTUP;
    else        state_q <= state_d;
  end

  assign state_o      = state_q;
  assign in_startup_o = (state_q == ST_STARTUP);

  AST_STARTUP_EXIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STARTUP && !(copy_done_i && count_ok_i)) |=> (state_q == ST_STARTUP)); // R2
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_STARTUP) |=> (state_q != ST_STARTUP)); // R2
  AST_SOF_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STANDBY && sof_i) |=> (state_q == ST_RECEIVE)); // R3
  AST_FRAME_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECEIVE && frame_end_i) |=> (state_q == ST_CONTROL)); // R4
  AST_NORESP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONTROL && no_resp_i) |=> (state_q == ST_STANDBY)); // R5
  AST_SENT_TO_STDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRANSMIT && resp_sent_i) |=> (state_q == ST_STANDBY)); // R6

endmodule

// File: rtl/tps_enable_reg.sv
module tps_enable_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  tps_pkg::tps_state_e state_i,
  output tps_pkg::tps_en_t    en_o
);
  import tps_pkg::*;

  tps_en_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= en_for_state(ST_STARTUP);
    else        en_q <= en_for_state(state_i);
  end

  assign en_o = en_q;

  AST_CMDDEC_NEEDS_SYMDET: assert property (@(posedge clk) disable iff (!rst_n)
    en_q.cmddec |-> en_q.symdet); // R7
  AST_TX_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q.tx |-> (!en_q.symdet && !en_q.ctrl && !en_q.shadow)); // R7
  AST_SHADOW_WITH_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    en_q.shadow == en_q.ctrl); // R7
  AST_PM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    en_q.pm); // R9

endmodule

// File: rtl/tag_power_seq.sv
module tag_power_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] copy_len_i,
  input  logic             copy_word_i,
  input  logic             copy_done_i,
  input  logic             sof_i,
  input  logic             frame_end_i,
  input  logic             reply_rdy_i,
  input  logic             no_resp_i,
  input  logic             resp_sent_i,
  output logic [2:0]       state_o,
  output logic             en_pm_o,
  output logic             en_symdet_o,
  output logic             en_cmddec_o,
  output logic             en_ctrl_o,
  output logic             en_mem_o,
  output logic             en_shadow_o,
  output logic             en_tx_o
);
  import tps_pkg::*;

  tps_state_e cur_state;
  tps_en_t    en_vec;
  logic       in_startup;
  logic       count_ok;

  tps_copy_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (in_startup),
    .word_i     (copy_word_i),
    .len_i      (copy_len_i),
    .count_ok_o (count_ok)
  );

  tps_state_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .copy_done_i  (copy_done_i),
    .count_ok_i   (count_ok),
    .sof_i        (sof_i),
    .frame_end_i  (frame_end_i),
    .reply_rdy_i  (reply_rdy_i),
    .no_resp_i    (no_resp_i),
    .resp_sent_i  (resp_sent_i),
    .state_o      (cur_state),
    .in_startup_o (in_startup)
  );

  tps_enable_reg u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (cur_state),
    .en_o    (en_vec)
  );

  assign state_o     = cur_state;
  assign en_pm_o     = en_vec.pm;
  assign en_symdet_o = en_vec.symdet;
  assign en_cmddec_o = en_vec.cmddec;
  assign en_ctrl_o   = en_vec.ctrl;
  assign en_mem_o    = en_vec.mem;
  assign en_shadow_o = en_vec.shadow;
  assign en_tx_o     = en_vec.tx;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4); // R10

endmodule

// File: tb/tag_power_seq_tb_top.sv
module tag_power_seq_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] copy_len = '0;
  logic copy_word = 0, copy_done = 0, sof = 0, frame_end = 0;
  logic reply_rdy = 0, no_resp = 0, resp_sent = 0;
  logic [2:0] state_o;
  logic en_pm, en_symdet, en_cmddec, en_ctrl, en_mem, en_shadow, en_tx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model
  int m_state = 0;
  int m_prev = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  tag_power_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .copy_len_i(copy_len), .copy_word_i(copy_word),
    .copy_done_i(copy_done), .sof_i(sof), .frame_end_i(frame_end),
    .reply_rdy_i(reply_rdy), .no_resp_i(no_resp), .resp_sent_i(resp_sent),
    .state_o(state_o), .en_pm_o(en_pm), .en_symdet_o(en_symdet),
    .en_cmddec_o(en_cmddec), .en_ctrl_o(en_ctrl), .en_mem_o(en_mem),
    .en_shadow_o(en_shadow), .en_tx_o(en_tx)
  );

  // expected enables {pm,symdet,cmddec,ctrl,mem,shadow,tx} per R7
  function automatic logic [6:0] exp_en(int s);
    logic sd, cd, ct, me, tx;
    sd = (s == 1) || (s == 2);
    cd = (s == 2);
    ct = (s == 0) || (s == 3);
    me = (s != 1);
    tx = (s == 4);
    return {1'b1, sd, cd, ct, me, ct, tx};
  endfunction

  function automatic logic [6:0] got_en();
    return {en_pm, en_symdet, en_cmddec, en_ctrl, en_mem, en_shadow, en_tx};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs: {word,done,sof,fend,rrdy,nresp,sent}
  task automatic cyc(input logic [6:0] v);
    int nxt;
    string tag;
    {copy_word, copy_done, sof, frame_end, reply_rdy, no_resp, resp_sent} = v;
    nxt = m_state;
    case (m_state)
      0: if (v[5] && m_cnt >= int'(copy_len)) nxt = 1;
      1: if (v[4]) nxt = 2;
      2: if (v[3]) nxt = 3;
      3: if (v[1]) nxt = 1; else if (v[2]) nxt = 4;
      4: if (v[0]) nxt = 1;
      default: nxt = 0;
    endcase
    if (m_state == 0 && v[6] && m_cnt < 255) m_cnt++;
    case (m_state)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      3: tag = "R5";
      default: tag = "R6";
    endcase
    if (nxt == m_state) tag = {tag, " R10"};
    m_prev = m_state;
    m_state = nxt;
    @(negedge clk);
    chk(int'(state_o) == m_state, {"state ", tag}, int'(state_o), m_state);
    chk(got_en() == exp_en(m_prev), "enables R7 R8", int'(got_en()), int'(exp_en(m_prev)));
    chk(en_pm == 1'b1, "pm R9", int'(en_pm), 1);
  endtask

  task automatic do_reset();
    {copy_word, copy_done, sof, frame_end, reply_rdy, no_resp, resp_sent} = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(state_o == 3'd0, "reset state R1", int'(state_o), 0);
    chk(got_en() == exp_en(0), "reset enables R1", int'(got_en()), int'(exp_en(0)));
    rst_n = 1'b1;
    m_state = 0; m_prev = 0; m_cnt = 0;
  endtask

  initial begin
    @(negedge clk);
    for (int len = 0; len <= 4; len++) begin
      for (int words = 0; words <= 5; words++) begin
        copy_len = CNT_W'(len);
        do_reset();
        // done before any word, then words, then done (R2)
        cyc(7'b0100000);
        for (int w = 0; w < words; w++) cyc(7'b1000000);
        cyc(7'b0000000);
        cyc(7'b1100000);   // word and done together: pre-increment count
        while (m_state == 0) begin
          cyc(7'b1000000);
          cyc(7'b0100000);
        end
        // sweep every handshake in every state, then the legal one
        for (int loop = 0; loop < 2; loop++) begin
          for (int b = 0; b < 7; b++) if (b != 4) cyc(7'(1 << b));  // standby, R10
          cyc(7'b0010000);                                          // R3
          for (int b = 0; b < 7; b++) if (b != 3) cyc(7'(1 << b));  // receive, R10
          cyc(7'b0001000);                                          // R4
          cyc(7'b0000001);  cyc(7'b1110000);                        // control, R10
          case ((len + words + loop) % 3)
            0: cyc(7'b0000010);   // no reply, R5
            1: cyc(7'b0000110);   // both: no reply wins, R5
            default: begin
              cyc(7'b0000100);    // reply ready, R5
              for (int b = 1; b < 7; b++) cyc(7'(1 << b));  // transmit, R10
              cyc(7'b0000001);    // R6
            end
          endcase
          cyc(7'b0000000);
        end
      end
    end
    // saturating counter: a long word burst with a maximum length (R2)
    copy_len = '1;
    do_reset();
    for (int w = 0; w < 300; w++) cyc(7'b1000000);
    cyc(7'b0100000);
    cyc(7'b0000000);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule